// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer with Byte Lanes

This block sits between a processor bus and a memory built from an even byte bank and an odd byte bank. The processor shares its low 16 pins between address and data. The block captures the address in a transparent latch while the address strobe is high. It then decodes the byte-high-enable signal together with address bit 0 into one select per bank. Two byte-lane buffers carry data between the processor side and the memory side. Their direction comes from the transmit/receive input and their enable from the data-enable input.

The 20-bit system address is made of the 16 shared lines and 4 upper lines. The banks use address bits 19:1 as the word location. The odd bank sits on lane 1 (bits 15:8) and the even bank on lane 0 (bits 7:0). A latch output enable turns the address outputs off. While it is off, no bank is selected and no buffer drives.

Top module: `bus_demux`

## Requirements
- R1: While rst_ni is low, and after it rises until the first address strobe, sys_addr_o is 0, both bank selects are 0 and no buffer output enable is set.
- R2: While ale_i is 1 and lat_oe_ni is 0, sys_addr_o equals {a_hi_i, ad_i} and follows any change on those inputs.
- R3: After ale_i falls, sys_addr_o, the latched byte-high-enable and the bank selects keep their values, whatever ad_i, a_hi_i and bhe_ni do, until ale_i rises again.
- R4: Bank selects are bank_sel_o[1] for the odd bank and bank_sel_o[0] for the even bank. With latched bhe_ni=0 and A0=0, both are 1 (word access).
- R5: With latched bhe_ni=0 and A0=1, only bank_sel_o[1] is 1 (odd byte on lane 1, bits 15:8).
- R6: With latched bhe_ni=1 and A0=0, only bank_sel_o[0] is 1 (even byte on lane 0, bits 7:0).
- R7: With latched bhe_ni=1 and A0=1, both bank selects are 0.
- R8: While lat_oe_ni is 1, sys_addr_o is 0, sys_addr_oe_o is 0, both bank selects are 0 and no buffer drives. While lat_oe_ni is 0, sys_addr_oe_o is 1.
- R9: With den_i=1 and dt_r_i=1 (transmit), mem_d_oe_o[k] is set for each selected lane k, and mem_d_o lane k carries ad_i lane k. cpu_d_oe_o is 0.
- R10: With den_i=1 and dt_r_i=0 (receive), cpu_d_oe_o[k] is set for each selected lane k, and cpu_d_o lane k carries mem_d_i lane k. mem_d_oe_o is 0.
- R11: With den_i=0, or for an unselected lane, neither output enable of that lane is set and both of its data outputs are 0. No lane ever drives both sides at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset, clears the latch |
| ale_i | input | 1 | Address strobe; the latch is transparent while it is high |
| lat_oe_ni | input | 1 | Active-low output enable of the latched address |
| ad_i | input | 16 | Shared address/data lines from the processor |
| a_hi_i | input | 4 | Upper address lines A19:A16 |
| bhe_ni | input | 1 | Active-low byte-high-enable from the processor |
| dt_r_i | input | 1 | Buffer direction: 1 toward memory, 0 toward processor |
| den_i | input | 1 | Buffer enable, active high |
| mem_d_i | input | 16 | Data read from the banks (odd bank on bits 15:8) |
| sys_addr_o | output | 20 | Latched system address |
| sys_addr_oe_o | output | 1 | Address output driver enable |
| bank_sel_o | output | 2 | Bank selects: bit 1 odd bank, bit 0 even bank |
| mem_d_o | output | 16 | Write data toward the banks |
| mem_d_oe_o | output | 2 | Per-lane drive enable toward memory |
| cpu_d_o | output | 16 | Read data toward the processor |
| cpu_d_oe_o | output | 2 | Per-lane drive enable toward the processor |

## Verification
The assertions evaluate continuously. They assume that each input pattern is held long enough for the combinational paths and the latch to settle, and that ale_i and den_i are never high together. The checks made while ale_i is high read the bank selects straight from the live bhe_ni and ad_i[0]. The bench drives every bus cycle in order: address phase with ale_i high, ale_i falls, data phase with den_i high, idle. It changes inputs only on clock edges and keeps the address strobe and data enable apart. Random addresses, byte-enable combinations and directions come from a fixed seed. Directed cases add reset, the tri-stated latch and the hold after the strobe falls.

// File: rtl/bus_demux_pkg.sv
package bus_demux_pkg;
  // encoding is {bhe_n, a0} as driven by the processor
  typedef enum logic [1:0] {
    ACC_WORD = 2'b00,
    ACC_ODD  = 2'b01,
    ACC_EVEN = 2'b10,
    ACC_NONE = 2'b11
  } acc_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/bdm_addr_latch.sv
module bdm_addr_latch #(
  parameter int unsigned W = 21
) (
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_latch begin
    if (!rst_ni)   q_o <= '0;
    else if (le_i) q_o <= d_i;
  end
endmodule

// File: rtl/bdm_bank_decode.sv
module bdm_bank_decode
  import bus_demux_pkg::*;
(
  input  logic       en_i,
  input  logic       bhe_ni,
  input  logic       a0_i,
  output logic [1:0] sel_o
);
  acc_e acc;
  assign acc = acc_e'({bhe_ni, a0_i});

  always_comb begin
    sel_o = 2'b00;
    if (en_i) begin
      unique case (acc)
        ACC_WORD: sel_o = 2'b11;
        ACC_ODD:  sel_o = 2'b10;
        ACC_EVEN: sel_o = 2'b01;
        ACC_NONE: sel_o = 2'b00;
      endcase
    end
  end
endmodule

// File: rtl/bdm_lane_buf.sv
module bdm_lane_buf #(
  parameter int unsigned W = 8
) (
  input  logic         sel_i,
  input  logic         den_i,
  input  logic         dt_r_i,
  input  logic [W-1:0] cpu_d_i,
  input  logic [W-1:0] mem_d_i,
  output logic [W-1:0] cpu_d_o,
  output logic         cpu_oe_o,
  output logic [W-1:0] mem_d_o,
  output logic         mem_oe_o
);
  logic act;
  assign act      = sel_i & den_i;
  assign mem_oe_o = act & dt_r_i;
  assign cpu_oe_o = act & ~dt_r_i;
  assign mem_d_o  = mem_oe_o ? cpu_d_i : '0;
  assign cpu_d_o  = cpu_oe_o ? mem_d_i : '0;
endmodule

// File: rtl/bus_demux.sv
module bus_demux
  import bus_demux_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic              lat_oe_ni,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [ADDR_W-DATA_W-1:0] a_hi_i,
  input  logic              bhe_ni,
  input  logic              dt_r_i,
  input  logic              den_i,
  input  logic [DATA_W-1:0] mem_d_i,
  output logic [ADDR_W-1:0] sys_addr_o,
  output logic              sys_addr_oe_o,
  output logic [1:0]        bank_sel_o,
  output logic [DATA_W-1:0] mem_d_o,
  output logic [1:0]        mem_d_oe_o,
  output logic [DATA_W-1:0] cpu_d_o,
  output logic [1:0]        cpu_d_oe_o
);
  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned LAT_W = ADDR_W + 2;  // valid, bhe_n, address

  logic [LAT_W-1:0]  lat_q;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_bhe_n, lat_vld, addr_en;
  logic [1:0]        sel;

  bdm_addr_latch #(.W(LAT_W)) u_latch (
    .rst_ni (rst_ni),
    .le_i   (ale_i),
    .d_i    ({1'b1, bhe_ni, a_hi_i, ad_i}),
    .q_o    (lat_q)
  );

  assign lat_addr  = lat_q[ADDR_W-1:0];
  assign lat_bhe_n = lat_q[ADDR_W];
  assign lat_vld   = lat_q[ADDR_W+1];
  assign addr_en   = ~lat_oe_ni;

  assign sys_addr_oe_o = addr_en;
  assign sys_addr_o    = addr_en ? lat_addr : '0;

  bdm_bank_decode u_dec (
    .en_i   (addr_en & lat_vld),
    .bhe_ni (lat_bhe_n),
    .a0_i   (lat_addr[0]),
    .sel_o  (sel)
  );
  assign bank_sel_o = sel;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bdm_lane_buf #(.W(LANE_W)) u_buf (
      .sel_i    (sel[k]),
      .den_i    (den_i),
      .dt_r_i   (dt_r_i),
      .cpu_d_i  (ad_i[k*LANE_W +: LANE_W]),
      .mem_d_i  (mem_d_i[k*LANE_W +: LANE_W]),
      .cpu_d_o  (cpu_d_o[k*LANE_W +: LANE_W]),
      .cpu_oe_o (cpu_d_oe_o[k]),
      .mem_d_o  (mem_d_o[k*LANE_W +: LANE_W]),
      .mem_oe_o (mem_d_oe_o[k])
    );
  end
endmodule

// File: rtl/bus_demux_chk.sv
module bus_demux_chk (
  input logic        rst_ni,
  input logic        ale_i,
  input logic        lat_oe_ni,
  input logic [15:0] ad_i,
  input logic [3:0]  a_hi_i,
  input logic        bhe_ni,
  input logic        dt_r_i,
  input logic        den_i,
  input logic [15:0] mem_d_i,
  input logic [19:0] sys_addr_o,
  input logic        sys_addr_oe_o,
  input logic [1:0]  bank_sel_o,
  input logic [15:0] mem_d_o,
  input logic [1:0]  mem_d_oe_o,
  input logic [15:0] cpu_d_o,
  input logic [1:0]  cpu_d_oe_o
);
  always_comb begin
    if (rst_ni) begin
      if (ale_i && !lat_oe_ni) begin
        a_r2_transparent: assert (sys_addr_o == {a_hi_i, ad_i});
        // R4 R5 R6 R7: selects follow live inputs while transparent
        a_r4_decode: assert (bank_sel_o == {~bhe_ni, ~ad_i[0]});
      end
      if (lat_oe_ni) begin
        a_r8_tristate: assert (sys_addr_o == '0 && bank_sel_o == 2'b00 && !sys_addr_oe_o);
      end
      a_r11_one_side: assert ((cpu_d_oe_o & mem_d_oe_o) == 2'b00);
      a_r11_den_off: assert (den_i || (cpu_d_oe_o == 2'b00 && mem_d_oe_o == 2'b00));
      a_r9_dir: assert ((mem_d_oe_o == 2'b00) || dt_r_i);
      a_r10_dir: assert ((cpu_d_oe_o == 2'b00) || !dt_r_i);
      for (int k = 0; k < 2; k++) begin
        a_r10_cpu_data: assert (cpu_d_o[k*8 +: 8] == (cpu_d_oe_o[k] ? mem_d_i[k*8 +: 8] : 8'h00));
        a_r9_mem_data: assert (mem_d_o[k*8 +: 8] == (mem_d_oe_o[k] ? ad_i[k*8 +: 8] : 8'h00));
      end
    end
  end
endmodule

bind bus_demux bus_demux_chk u_chk (.*);

// File: tb/bus_demux_test.sv
module bus_demux_test;
  localparam int unsigned CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_ni, ale_i, lat_oe_ni, bhe_ni, dt_r_i, den_i;
  logic [15:0] ad_i, mem_d_i;
  logic [3:0]  a_hi_i;
  logic [19:0] sys_addr_o;
  logic        sys_addr_oe_o;
  logic [1:0]  bank_sel_o, mem_d_oe_o, cpu_d_oe_o;
  logic [15:0] mem_d_o, cpu_d_o;

  int total = 0;
  int bad   = 0;

  bus_demux uut (
    .rst_ni, .ale_i, .lat_oe_ni, .ad_i, .a_hi_i, .bhe_ni, .dt_r_i, .den_i,
    .mem_d_i, .sys_addr_o, .sys_addr_oe_o, .bank_sel_o, .mem_d_o,
    .mem_d_oe_o, .cpu_d_o, .cpu_d_oe_o
  );

  function automatic logic [1:0] exp_sel(input logic bhe_n, input logic a0);
    return {~bhe_n, ~a0};
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] s);
    return {{8{s[1]}}, {8{s[0]}}};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic bus_cycle(input logic [19:0] addr, input logic bhe_n,
                           input logic wr, input logic [15:0] wdata,
                           input logic [15:0] rdata);
    logic [1:0] s;
    s = exp_sel(bhe_n, addr[0]);
    @(posedge clk);
    ale_i = 1'b1; ad_i = addr[15:0]; a_hi_i = addr[19:16]; bhe_ni = bhe_n;
    step();
    chk("R2", sys_addr_o, addr);
    chk("R4-7 sel", bank_sel_o, s);
    @(posedge clk);
    ale_i = 1'b0;
    step();
    @(posedge clk);
    ad_i = wr ? wdata : ~addr[15:0]; a_hi_i = ~addr[19:16]; bhe_ni = ~bhe_n;
    mem_d_i = rdata; dt_r_i = wr; den_i = 1'b1;
    step();
    chk("R3 hold addr", sys_addr_o, addr);
    chk("R3 hold sel", bank_sel_o, s);
    if (wr) begin
      chk("R9 mem_oe", mem_d_oe_o, s);
      chk("R9 mem_d", mem_d_o, wdata & lane_mask(s));
      chk("R9 cpu_oe", cpu_d_oe_o, 2'b00);
    end else begin
      chk("R10 cpu_oe", cpu_d_oe_o, s);
      chk("R10 cpu_d", cpu_d_o, rdata & lane_mask(s));
      chk("R10 mem_oe", mem_d_oe_o, 2'b00);
    end
    @(posedge clk);
    den_i = 1'b0;
    step();
    chk("R11 idle", {cpu_d_oe_o, mem_d_oe_o}, 4'h0);
    chk("R11 idle data", {cpu_d_o, mem_d_o}, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    rst_ni = 1'b0; ale_i = 1'b0; lat_oe_ni = 1'b0; bhe_ni = 1'b0;
    dt_r_i = 1'b0; den_i = 1'b0; ad_i = 16'h1234; a_hi_i = 4'h5; mem_d_i = 16'hFFFF;
    step();
    chk("R1 addr", sys_addr_o, 20'h0);
    chk("R1 sel", bank_sel_o, 2'b00);
    @(posedge clk); rst_ni = 1'b1; den_i = 1'b1;
    step();
    chk("R1 after release sel", bank_sel_o, 2'b00);
    chk("R1 after release oe", {cpu_d_oe_o, mem_d_oe_o}, 4'h0);
    @(posedge clk); den_i = 1'b0;

    // directed: the four byte-enable combinations
    bus_cycle(20'hA8224, 1'b0, 1'b1, 16'hBEEF, 16'h0);   // R4 word
    bus_cycle(20'h0B501, 1'b0, 1'b0, 16'h0, 16'hC3A5);   // R5 odd
    bus_cycle(20'hFFFF0, 1'b1, 1'b1, 16'h5A69, 16'h0);   // R6 even
    bus_cycle(20'h12345, 1'b1, 1'b0, 16'h0, 16'h7E81);   // R7 none

    // R3: strobe low, inputs wander, output stays
    @(posedge clk); ale_i = 1'b1; ad_i = 16'h0F0E; a_hi_i = 4'h9; bhe_ni = 1'b0;
    @(posedge clk); ale_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); ad_i = 16'($urandom); a_hi_i = 4'($urandom); bhe_ni = ~bhe_ni;
      step();
      chk("R3 wander", sys_addr_o, 20'h90F0E);
      chk("R3 wander sel", bank_sel_o, 2'b11);
    end

    // R8: latch outputs off
    @(posedge clk); lat_oe_ni = 1'b1; den_i = 1'b1; dt_r_i = 1'b0;
    step();
    chk("R8 addr", sys_addr_o, 20'h0);
    chk("R8 addr_oe", sys_addr_oe_o, 1'b0);
    chk("R8 sel", bank_sel_o, 2'b00);
    chk("R8 buffers", {cpu_d_oe_o, mem_d_oe_o}, 4'h0);
    @(posedge clk); lat_oe_ni = 1'b0;
    step();
    chk("R8 addr restored", sys_addr_o, 20'h90F0E);
    chk("R8 addr_oe on", sys_addr_oe_o, 1'b1);
    @(posedge clk); den_i = 1'b0;

    // random bus cycles
    for (int n = 0; n < 200; n++) begin
      bus_cycle(20'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
    end

    // reset mid-operation clears the latch
    @(posedge clk); rst_ni = 1'b0;
    step();
    chk("R1 mid reset", {sys_addr_o, bank_sel_o}, 22'h0);
    @(posedge clk); rst_ni = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule